// File: doc/BRIEF.md
# Interleaved I/Q Input Demultiplexer

This block takes one stream of words on a single data port, in which I and Q samples alternate, and sorts them into separate I and Q channel samples. It derives a word clock from a fast internal clock, at twice the per-channel sample rate. A select line is sampled together with each data word and steers that word to I or Q. Once the block holds one word of each channel, it presents the aligned pair with a valid strobe that lasts one cycle, so pairs appear at the per-channel rate.

Two configuration bits change the interface. One swaps the sense of the select line. The other inverts the word clock seen at the pin, which moves capture to the falling edge of that pin without moving the capture instant. A two-bit interpolation code is also checked. Code 0 (1x) is illegal in this interleaved mode, so words captured under it are discarded and a sticky error flag is set. The block also reports the output sample rate as a multiple of the per-channel (reference) rate.

Pairing is handled by a three-state machine. ST_EMPTY holds no partial pair. ST_GOT_I holds an I word and waits for Q. ST_GOT_Q holds a Q word and waits for I. The transitions are:
- T_FIRST_I: ST_EMPTY to ST_GOT_I.
- T_FIRST_Q: ST_EMPTY to ST_GOT_Q.
- T_PAIR: ST_GOT_I on a Q word, or ST_GOT_Q on an I word. It returns to ST_EMPTY and releases the pair.
- T_REPEAT: a second word for the channel already held. The state stays the same, the held word is overwritten and the ordering flag is set.

Top module: `iq_demux_top`

## Requirements
- R1: `word_clk` has a period of 2*DIV_HALF `clk` cycles and a 50% duty cycle. Reset clears its internal phase to 0, so `word_clk` equals `wclk_invert` right after reset.
- R2: A word and its select bit are captured at the `clk` edge where `word_clk` rises when `wclk_invert`=0, and where it falls when `wclk_invert`=1. Inversion does not move the capture instant.
- R3: With `sel_invert`=0, a captured select of 1 steers the word to I and a select of 0 steers it to Q.
- R4: With `sel_invert`=1, a select of 1 steers the word to Q and a select of 0 steers it to I.
- R5: When a capture completes one I word and one Q word, `pair_valid` is high for exactly one `clk` cycle, starting at that capture edge. In that same cycle `i_data`/`q_data` change to the most recent word of each channel. At all other times they hold their values.
- R6: If a word is captured for the channel already held, it overwrites the held word and sets the sticky `order_err`. No pair is released.
- R7: `interp_code` 1, 2 and 3 mean 2x, 4x and 8x. Code 0 (1x) at a capture sets the sticky `mode_err`, discards the word, leaves the pair state unchanged, releases no pair and keeps the outputs unchanged.
- R8: `rate_mult` equals 2^`interp_code`, doubled again when `zero_stuff`=1. It is combinational.
- R9: Synchronous active-high `rst` clears the pair state, `i_data`, `q_data`, `pair_valid`, `mode_err`, `order_err` and the word-clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | DW | Interleaved sample word |
| sel_in | input | 1 | Channel select, sampled with the word |
| sel_invert | input | 1 | Swaps the select sense |
| wclk_invert | input | 1 | Inverts the word clock at the pin |
| interp_code | input | 2 | Interpolation: 0=1x (illegal), 1=2x, 2=4x, 3=8x |
| zero_stuff | input | 1 | Zero stuffing enabled |
| word_clk | output | 1 | Generated word clock |
| i_data | output | DW | Released I sample |
| q_data | output | DW | Released Q sample |
| pair_valid | output | 1 | One-cycle pair strobe |
| mode_err | output | 1 | Sticky illegal-rate flag |
| order_err | output | 1 | Sticky repeated-channel flag |
| rate_mult | output | 5 | Output rate / reference rate |

## Verification
The hardest cases to reach are the T_REPEAT transitions that overlap changes of `sel_invert`. In these, the same raw select value lands in opposite channels on consecutive captures, and the overwrite-then-pair order must still come out right. The same applies to captures made under the illegal 1x code while a partial pair is held. The bench locks onto the capture instant by watching the pin clock together with the inversion bit. It drives one word per capture and flips the select polarity, clock inversion and rate code at random between captures. Directed sequences force the repeat and 1x cases with a pair half-built.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_GOT_I = 2'd1,
        ST_GOT_Q = 2'd2
    } pair_st_e;

    localparam logic [1:0] CODE_1X = 2'd0;

    // Output sample rate as a multiple of the per-channel reference rate.
    function automatic logic [4:0] rate_factor(input logic [1:0] code, input logic zs);
        logic [4:0] base;
        base = 5'd1 << code;
        return zs ? (base << 1) : base;
    endfunction

endpackage

// File: rtl/iq_wordclk_gen.sv
module iq_wordclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_inv,
    output logic word_clk,
    output logic capture
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // Capture at the edge where the internal phase rises.
    assign capture  = (cnt == LAST) && !phase;
    assign word_clk = phase ^ clk_inv;

    a_r1_spacing: assert property (@(posedge clk) disable iff (rst)
        capture |=> !capture);

    a_r2_rise_edge: assert property (@(posedge clk) disable iff (rst)
        (capture && !clk_inv) |=> (word_clk || clk_inv));

    a_r2_fall_edge: assert property (@(posedge clk) disable iff (rst)
        (capture && clk_inv) |=> (!word_clk || !clk_inv));

endmodule

// File: rtl/iq_chan_steer.sv
module iq_chan_steer (
    input  logic sel,
    input  logic sel_inv,
    output logic to_i
);
    // R3: select 1 means I; R4: the inversion bit swaps that sense.
    always_comb begin
        unique case (sel_inv)
            1'b0: to_i = sel;
            1'b1: to_i = !sel;
            default: to_i = sel;
        endcase
    end
endmodule

// File: rtl/iq_pair_fsm.sv
module iq_pair_fsm
    import iq_demux_pkg::*;
#(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          to_i,
    input  logic [DW-1:0] word,
    input  logic [1:0]    code,
    output logic [DW-1:0] i_out,
    output logic [DW-1:0] q_out,
    output logic          pair_valid,
    output logic          mode_err,
    output logic          order_err
);
    pair_st_e      st, st_nxt;
    logic          take, release_pair, repeat_hit;
    logic [DW-1:0] hold_i, hold_q;

    assign take = capture && (code != CODE_1X);

    always_comb begin
        st_nxt       = st;
        release_pair = 1'b0;
        repeat_hit   = 1'b0;
        unique case (st)
            ST_EMPTY: if (take) st_nxt = to_i ? ST_GOT_I : ST_GOT_Q;  // T_FIRST_I / T_FIRST_Q
            ST_GOT_I: if (take) begin
                if (to_i) repeat_hit = 1'b1;                            // T_REPEAT
                else begin release_pair = 1'b1; st_nxt = ST_EMPTY; end  // T_PAIR
            end
            ST_GOT_Q: if (take) begin
                if (!to_i) repeat_hit = 1'b1;                           // T_REPEAT
                else begin release_pair = 1'b1; st_nxt = ST_EMPTY; end  // T_PAIR
            end
            default: st_nxt = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_EMPTY;
        else     st <= st_nxt;
    end

    // Outputs and held words
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_i     <= '0;
            hold_q     <= '0;
            i_out      <= '0;
            q_out      <= '0;
            pair_valid <= 1'b0;
            mode_err   <= 1'b0;
            order_err  <= 1'b0;
        end else begin
            if (take && to_i)  hold_i <= word;
            if (take && !to_i) hold_q <= word;
            pair_valid <= release_pair;
            if (release_pair) begin
                i_out <= to_i ? word   : hold_i;
                q_out <= to_i ? hold_q : word;
            end
            mode_err  <= mode_err  | (capture && code == CODE_1X);
            order_err <= order_err | repeat_hit;
        end
    end

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    a_r5_hold_i: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> $stable(i_out));

    a_r5_hold_q: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> $stable(q_out));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        order_err |=> order_err);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);

    a_r7_no_release: assert property (@(posedge clk) disable iff (rst)
        (capture && code == CODE_1X) |=> (!pair_valid && mode_err));

endmodule

// File: rtl/iq_demux_top.sv
module iq_demux_top
    import iq_demux_pkg::*;
#(
    parameter int DW       = 14,
    parameter int DIV_HALF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] data_in,
    input  logic          sel_in,
    input  logic          sel_invert,
    input  logic          wclk_invert,
    input  logic [1:0]    interp_code,
    input  logic          zero_stuff,
    output logic          word_clk,
    output logic [DW-1:0] i_data,
    output logic [DW-1:0] q_data,
    output logic          pair_valid,
    output logic          mode_err,
    output logic          order_err,
    output logic [4:0]    rate_mult
);
    logic capture;
    logic to_i;

    iq_wordclk_gen #(.DIV_HALF(DIV_HALF)) u_wclk (
        .clk      (clk),
        .rst      (rst),
        .clk_inv  (wclk_invert),
        .word_clk (word_clk),
        .capture  (capture)
    );

    iq_chan_steer u_steer (
        .sel     (sel_in),
        .sel_inv (sel_invert),
        .to_i    (to_i)
    );

    iq_pair_fsm #(.DW(DW)) u_pair (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .to_i       (to_i),
        .word       (data_in),
        .code       (interp_code),
        .i_out      (i_data),
        .q_out      (q_data),
        .pair_valid (pair_valid),
        .mode_err   (mode_err),
        .order_err  (order_err)
    );

    assign rate_mult = rate_factor(interp_code, zero_stuff);

endmodule

// File: tb/iq_demux_top_tb_top.sv
module iq_demux_top_tb_top;
    localparam int DW       = 14;
    localparam int DIV_HALF = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          sel_in = 1'b0;
    logic          sel_invert = 1'b0;
    logic          wclk_invert = 1'b0;
    logic [1:0]    interp_code = 2'd1;
    logic          zero_stuff = 1'b0;
    logic          word_clk, pair_valid, mode_err, order_err;
    logic [DW-1:0] i_data, q_data;
    logic [4:0]    rate_mult;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    int            m_st = 0;          // 0 empty, 1 holds I, 2 holds Q
    logic [DW-1:0] m_hi = '0, m_hq = '0, m_i = '0, m_q = '0;
    bit            m_merr = 0, m_oerr = 0;
    bit            prev_ph = 0;
    int            since = 0;
    bit            first = 1;

    always #10 clk = ~clk;   // 50 MHz

    iq_demux_top #(.DW(DW), .DIV_HALF(DIV_HALF)) dut_i (
        .clk(clk), .rst(rst), .data_in(data_in), .sel_in(sel_in),
        .sel_invert(sel_invert), .wclk_invert(wclk_invert),
        .interp_code(interp_code), .zero_stuff(zero_stuff),
        .word_clk(word_clk), .i_data(i_data), .q_data(q_data),
        .pair_valid(pair_valid), .mode_err(mode_err), .order_err(order_err),
        .rate_mult(rate_mult)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_rate(input logic [1:0] c, input logic zs);
        int f;
        f = 1;
        for (int k = 0; k < c; k++) f = f * 2;
        if (zs) f = f * 2;
        return 5'(f);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_st = 0; m_hi = '0; m_hq = '0; m_i = '0; m_q = '0;
        m_merr = 0; m_oerr = 0; prev_ph = 0; since = 0; first = 1;
        chk(word_clk == wclk_invert, "R9/R1", "word_clk after reset", word_clk, wclk_invert);
        chk(i_data == 0 && q_data == 0, "R9", "data after reset", i_data, 0);
        chk(!pair_valid && !mode_err && !order_err, "R9", "flags after reset",
            {pair_valid, mode_err, order_err}, 0);
    endtask

    // Drive one word, wait for its capture, update model, compare.
    task automatic step(input logic [DW-1:0] d, input logic s);
        bit hit, ph, is_i, rel, exp_v;
        data_in = d;
        sel_in  = s;
        hit = 0;
        while (!hit) begin
            @(negedge clk);
            since++;
            ph = word_clk ^ wclk_invert;
            hit = ph && !prev_ph;
            prev_ph = ph;
            if (!hit) chk(!pair_valid, "R5", "valid outside capture", pair_valid, 0);
        end
        if (!first) chk(since == 2 * DIV_HALF, "R1", "capture spacing", since, 2 * DIV_HALF);
        chk(word_clk == !wclk_invert, "R2", "pin edge at capture", word_clk, !wclk_invert);
        first = 0;
        since = 0;
        rel = 0;
        if (interp_code == 2'd0) begin
            m_merr = 1;                                    // R7
        end else begin
            is_i = sel_invert ? !s : s;                    // R3, R4
            if (m_st == 0) begin
                m_st = is_i ? 1 : 2;
                if (is_i) m_hi = d; else m_hq = d;
            end else if ((m_st == 1) == is_i) begin
                m_oerr = 1;                                // R6
                if (is_i) m_hi = d; else m_hq = d;
            end else begin
                if (is_i) m_hi = d; else m_hq = d;
                m_i = m_hi; m_q = m_hq; m_st = 0; rel = 1; // R5
            end
        end
        exp_v = rel;
        chk(pair_valid == exp_v, "R5", "pair_valid", pair_valid, exp_v);
        chk(i_data == m_i, "R3/R4/R5", "i_data", i_data, m_i);
        chk(q_data == m_q, "R3/R4/R5", "q_data", q_data, m_q);
        chk(mode_err == m_merr, "R7", "mode_err", mode_err, m_merr);
        chk(order_err == m_oerr, "R6", "order_err", order_err, m_oerr);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        do_reset();

        // R8: rate multiplier over all codes, inside one low clock phase
        for (int c = 0; c < 4; c++) begin
            for (int z = 0; z < 2; z++) begin
                interp_code = 2'(c); zero_stuff = z[0];
                #1;
                chk(rate_mult == exp_rate(2'(c), z[0]), "R8", "rate_mult", rate_mult, exp_rate(2'(c), z[0]));
            end
        end
        interp_code = 2'd1; zero_stuff = 1'b0;

        // R3: I then Q, Q then I
        step(14'h0123, 1'b1); step(14'h0456, 1'b0);
        step(14'h0AAA, 1'b0); step(14'h0555, 1'b1);
        // R6: repeat I then Q
        step(14'h1111, 1'b1); step(14'h2222, 1'b1); step(14'h3333, 1'b0);
        // R4: swapped select
        sel_invert = 1'b1;
        step(14'h0F0F, 1'b1); step(14'h00F0, 1'b0);
        // R2: inverted pin clock
        wclk_invert = 1'b1;
        step(14'h1234, 1'b0); step(14'h0321, 1'b1);
        wclk_invert = 1'b0; sel_invert = 1'b0;
        // R7: 1x with half pair held
        step(14'h0777, 1'b1);
        interp_code = 2'd0;
        step(14'h3FFF, 1'b0); step(14'h3EEE, 1'b1);
        interp_code = 2'd3;
        step(14'h0888, 1'b0);

        do_reset();
        // random mix
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(15) == 0) sel_invert  = ~sel_invert;
            if ($urandom_range(15) == 0) wclk_invert = ~wclk_invert;
            if ($urandom_range(39) == 0) interp_code = 2'd0;
            else if ($urandom_range(7) == 0) interp_code = 2'($urandom_range(3, 1));
            step(DW'($urandom), 1'($urandom));
            if (n == 700) begin
                interp_code = 2'd2;
                do_reset();
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule